// File: doc/BRIEF.md
# Self-Timed Power-On Reset Pulse Generator

This block makes a local reset pulse right after the device comes out of configuration. It has no reset input of its own. Its only input is the clock. A small up-counter starts at all zeros because it is given a one-time initial value, not a clocked reset. The counter moves up by one on every clock edge. The reset output is asserted while the count lies in a window set by two thresholds. When the count reaches the upper threshold it stops for good, so the reset stays released for as long as the clock runs.

A phase decoder sorts the count into one of three named states. `PH_WAIT` covers counts below the assert threshold. `PH_HOLD` covers counts from the assert threshold up to, but not including, the release threshold. `PH_FROZEN` is the release threshold itself, where the counter stops. The transitions are `PH_WAIT -> PH_HOLD`, taken when the count reaches the assert threshold, and `PH_HOLD -> PH_FROZEN`, taken when the count reaches the release threshold. No transition leaves `PH_FROZEN`. The output process registers the pulse, so the pulse follows the phase by one clock and has no glitches. The active level is a parameter. The default build uses a 4-bit counter, asserts reset at count 2, releases it at count 4, and drives reset active-high.

Top module: `por_pulse_gen`

## Requirements
- R1: Before the first clock edge, the reset output is at its inactive level. It stays inactive after each of edges 1 through ASSERT_AT.
- R2: The counter starts at zero and advances by exactly one per clock edge. As a result, the first asserted sample follows edge ASSERT_AT+1.
- R3: After clock edge k, the reset output is at its active level exactly when ASSERT_AT+1 <= k <= RELEASE_AT.
- R4: The reset pulse lasts exactly RELEASE_AT - ASSERT_AT clock cycles.
- R5: Once the counter reaches RELEASE_AT it holds that value. The reset output is inactive after every edge beyond RELEASE_AT and never asserts a second time.
- R6: With RST_ACTIVE_HIGH = 1 the active level is 1. With RST_ACTIVE_HIGH = 0 the active level is 0 and the inactive level is 1. The timing of R1 to R5 is the same for both settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Free-running clock. It is the only input. |
| rst_o | output | 1 | Registered reset pulse. Its polarity is set by RST_ACTIVE_HIGH. |

## Verification
The assertions assume two things about the inputs. First, the clock toggles freely from power-up. Second, the counter and output register hold their initial values before the first edge, because no reset exists to put them there. A flag that turns on at the first edge gates the assertions, so no property reads values from before the first clock. The bench never drives anything except the clock. It starts the clock at time zero and lets the initial values load, so the stimulus stays inside those assumptions. It runs two builds, the default one and an active-low one with a wider counter and a longer window.

// File: rtl/por_pkg.sv
package por_pkg;

    typedef enum logic [1:0] {
        PH_WAIT   = 2'd0,
        PH_HOLD   = 2'd1,
        PH_FROZEN = 2'd2
    } por_phase_t;

endpackage

// File: rtl/por_tick_counter.sv
module por_tick_counter #(
    parameter int CNT_W      = 4,
    parameter int RELEASE_AT = 4
) (
    input  logic             clk_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] STOP_C = CNT_W'(RELEASE_AT);
    localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

    // Power-up value comes from a one-time initial assignment, no reset.
    logic [CNT_W-1:0] cnt_q = '0;
    logic             live_q = 1'b0;

    always_ff @(posedge clk_i) begin
        if (cnt_q != STOP_C) begin
            cnt_q <= cnt_q + ONE_C;
        end
    end

    always_ff @(posedge clk_i) begin
        live_q <= 1'b1;
    end

    assign cnt_o = cnt_q;

    // R2: one step per edge while below the stop value
    a_r2_step: assert property (@(posedge clk_i) disable iff (!live_q)
        (cnt_q != STOP_C) |=> (cnt_q == $past(cnt_q) + ONE_C));

    // R5: counter frozen once the stop value is reached
    a_r5_frozen: assert property (@(posedge clk_i) disable iff (!live_q)
        (cnt_q == STOP_C) |=> (cnt_q == STOP_C));

endmodule

// File: rtl/por_phase_decode.sv
module por_phase_decode
    import por_pkg::*;
#(
    parameter int CNT_W      = 4,
    parameter int ASSERT_AT  = 2,
    parameter int RELEASE_AT = 4
) (
    input  logic [CNT_W-1:0] cnt_i,
    output por_phase_t       phase_o
);

    localparam logic [CNT_W-1:0] LO_C = CNT_W'(ASSERT_AT);
    localparam logic [CNT_W-1:0] HI_C = CNT_W'(RELEASE_AT);

    always_comb begin
        if (cnt_i < LO_C) begin
            phase_o = PH_WAIT;
        end else if (cnt_i < HI_C) begin
            phase_o = PH_HOLD;
        end else begin
            phase_o = PH_FROZEN;
        end
    end

endmodule

// File: rtl/por_pulse_gen.sv
module por_pulse_gen
    import por_pkg::*;
#(
    parameter int CNT_W           = 4,
    parameter int ASSERT_AT       = 2,
    parameter int RELEASE_AT      = 4,
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic clk_i,
    output logic rst_o
);

    localparam logic ON_LVL  = RST_ACTIVE_HIGH;
    localparam logic OFF_LVL = !RST_ACTIVE_HIGH;
    localparam int   CNT_MAX = (1 << CNT_W) - 1;

    generate
        if (ASSERT_AT >= RELEASE_AT || RELEASE_AT > CNT_MAX || ASSERT_AT < 0) begin : g_bad_cfg
            $error("por_pulse_gen: need 0 <= ASSERT_AT < RELEASE_AT <= 2**CNT_W-1");
        end
    endgenerate

    logic [CNT_W-1:0] cnt;
    por_phase_t       phase;
    logic             rst_q  = !RST_ACTIVE_HIGH;
    logic             live_q = 1'b0;

    por_tick_counter #(
        .CNT_W      (CNT_W),
        .RELEASE_AT (RELEASE_AT)
    ) u_cnt (
        .clk_i (clk_i),
        .cnt_o (cnt)
    );

    por_phase_decode #(
        .CNT_W      (CNT_W),
        .ASSERT_AT  (ASSERT_AT),
        .RELEASE_AT (RELEASE_AT)
    ) u_dec (
        .cnt_i   (cnt),
        .phase_o (phase)
    );

    // Output process: registered pulse level per phase
    always_ff @(posedge clk_i) begin
        unique case (phase)
            PH_HOLD:   rst_q <= ON_LVL;
            PH_WAIT:   rst_q <= OFF_LVL;
            PH_FROZEN: rst_q <= OFF_LVL;
            default:   rst_q <= OFF_LVL;
        endcase
    end

    always_ff @(posedge clk_i) begin
        live_q <= 1'b1;
    end

    assign rst_o = rst_q;

    // R1: no pulse while still waiting
    a_r1_quiet_wait: assert property (@(posedge clk_i) disable iff (!live_q)
        (phase == PH_WAIT) |=> (rst_o == OFF_LVL));

    // R3: pulse present one cycle after the hold phase
    a_r3_hold_drives: assert property (@(posedge clk_i) disable iff (!live_q)
        (phase == PH_HOLD) |=> (rst_o == ON_LVL));

    // R5: frozen phase keeps the reset released
    a_r5_no_reassert: assert property (@(posedge clk_i) disable iff (!live_q)
        (phase == PH_FROZEN) |=> (rst_o == OFF_LVL));

    // R5: frozen phase is absorbing
    a_r5_phase_sticky: assert property (@(posedge clk_i) disable iff (!live_q)
        (phase == PH_FROZEN) |=> (phase == PH_FROZEN));

endmodule

// File: tb/tb_por_pulse_gen.sv
module tb_por_pulse_gen;

    localparam int A0 = 2;
    localparam int R0 = 4;
    localparam int A1 = 5;
    localparam int R1_AT = 17;
    localparam int RUN_CYCLES = 60;

    logic clk = 1'b0;
    logic rst_hi;
    logic rst_lo;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 1'b0;

    por_pulse_gen dut (
        .clk_i (clk),
        .rst_o (rst_hi)
    );

    por_pulse_gen #(
        .CNT_W           (6),
        .ASSERT_AT       (A1),
        .RELEASE_AT      (R1_AT),
        .RST_ACTIVE_HIGH (1'b0)
    ) dut_low (
        .clk_i (clk),
        .rst_o (rst_lo)
    );

    always #10 clk = ~clk;

    always @(posedge clk) edges = edges + 1;

    function automatic bit model_on(int k, int a, int r);
        return (k >= a + 1) && (k <= r);
    endfunction

    function automatic string region_tag(int k, int a, int r);
        if (k <= a) return "R1";
        if (k <= r) return "R3";
        return "R5";
    endfunction

    task automatic check(string tag, int actual, int expected);
        checks++;
        if (actual !== expected) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (edge %0d)", tag, actual, expected, edges);
        end
    endtask

    initial begin
        int rises_hi = 0, rises_lo = 0;
        int width_hi = 0, width_lo = 0;
        int first_hi = -1, first_lo = -1;
        bit prev_hi = 1'b0, prev_lo = 1'b0;
        #5;
        check("R1 pre-edge high build", int'(rst_hi), 0);
        check("R1 R6 pre-edge low build", int'(rst_lo), 1);
        for (int c = 0; c < RUN_CYCLES; c++) begin
            bit on_hi, on_lo;
            @(negedge clk);
            on_hi = (rst_hi == 1'b1);
            on_lo = (rst_lo == 1'b0);
            check(region_tag(edges, A0, R0), int'(on_hi), int'(model_on(edges, A0, R0)));
            check({"R6 ", region_tag(edges, A1, R1_AT)}, int'(on_lo), int'(model_on(edges, A1, R1_AT)));
            if (on_hi && !prev_hi) begin rises_hi++; if (first_hi < 0) first_hi = edges; end
            if (on_lo && !prev_lo) begin rises_lo++; if (first_lo < 0) first_lo = edges; end
            if (on_hi) width_hi++;
            if (on_lo) width_lo++;
            prev_hi = on_hi;
            prev_lo = on_lo;
        end
        check("R2 first asserted edge high build", first_hi, A0 + 1);
        check("R2 first asserted edge low build", first_lo, A1 + 1);
        check("R4 pulse width high build", width_hi, R0 - A0);
        check("R4 pulse width low build", width_lo, R1_AT - A1);
        check("R5 single pulse high build", rises_hi, 1);
        check("R5 single pulse low build", rises_lo, 1);
        check("R5 released at end high build", int'(rst_hi), 0);
        check("R6 released level low build", int'(rst_lo), 1);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule